// File: doc/BRIEF.md
# Asymmetric Two-Phase Interleaved PWM

This block drives the two switching stages of an input-parallel, output-series boost converter. Both stages switch at one frequency, half a switching period apart, but they run at different duty ratios. The first stage follows the base duty command directly. The second stage uses the base command multiplied by a programmable ratio. This lets the two inductor and capacitor pairs be sized so that their ripples cancel at the nominal operating point.

A single up/down counter forms the triangular carrier of phase A. Phase B compares against the mirror image of that carrier, which is the half-period value minus the count, so the two carriers are shifted by 180 degrees. The half period, duty command and ratio are captured together at the carrier-A valley. Each stage has a registered main gate signal and a registered complementary gate signal. A strobe marks every carrier turning point so that converter currents can be sampled there.

Top module: `asym_pwm2`

## Requirements
- R1: While `rst_n` is low, `gate_a` and `gate_b` are 0, `gate_a_n` and `gate_b_n` are 1, and `sample_stb` is 0.
- R2: Carrier A counts 0, 1, ..., P, P-1, ..., 1 and then repeats, so one period lasts 2P clocks. P is the half period captured at the last valley (count 0). If the captured P is 0, the count stays at 0.
- R3: `gate_a` is 1 in the clock after carrier A holds value c exactly when d1 > c, where d1 = min(duty_cmd, P).
- R4: Carrier B equals P minus carrier A, so B is at its peak when A is at its valley.
- R5: `gate_b` is 1 in the clock after carrier B holds value c exactly when d2 > c. Here d2 = min(floor(duty_cmd * ratio_k / 2^15), P), and `ratio_k` is unsigned Q1.15 (0x8000 is 1.0, 0x4CCD is about 0.6).
- R6: `gate_a_n` is always the inverse of `gate_a`, and `gate_b_n` is always the inverse of `gate_b`.
- R7: `half_period`, `duty_cmd` and `ratio_k` are captured only in a clock where carrier A is 0. Changes made at other times have no effect on any output until the next valley.
- R8: `sample_stb` is 1 in the clock after carrier A is at 0 or at P, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | 16 | Carrier half period P in clocks |
| duty_cmd | input | 16 | Base duty compare value for phase A |
| ratio_k | input | 16 | Phase-B ratio, unsigned Q1.15 |
| gate_a | output | 1 | Phase A main switch |
| gate_a_n | output | 1 | Phase A complementary switch |
| gate_b | output | 1 | Phase B main switch |
| gate_b_n | output | 1 | Phase B complementary switch |
| sample_stb | output | 1 | One-clock strobe at each carrier turning point |

## Verification
The capture of new commands at the valley falls in the same clock as a strobe and as a compare against the old values. The bench changes the command in the middle of a period and again right at valley cycles, and it expects the old duties to hold through that valley's compare. A half period of 1 puts a peak and a valley on alternate clocks. A half period of 0 makes the valley and peak conditions true together on every clock, and the bench then expects a strobe on every clock with both gates low. Each case is judged against a cycle-accurate reference carried in the scoreboard.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    typedef struct packed {
        logic gate;
        logic gate_n;
    } gate_pair_t;
endpackage

// File: rtl/pwm2_carrier.sv
module pwm2_carrier #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] per_in,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] per,
    output logic          valley,
    output logic          peak
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
        logic          up;
    } car_st_t;

    car_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.per = per_in;
            st_d.up  = 1'b1;
            st_d.cnt = (per_in == '0) ? '0 : CW'(1);
        end else if (st_q.up) begin
            if (st_q.cnt == st_q.per) begin
                st_d.up  = 1'b0;
                st_d.cnt = st_q.cnt - CW'(1);
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign per    = st_q.per;
    assign valley = (st_q.cnt == '0);
    assign peak   = (st_q.cnt == st_q.per);

    // R2
    cnt_le_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.per);

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) + CW'(1)) ||
                             (st_q.cnt == $past(st_q.cnt) - CW'(1)));
endmodule

// File: rtl/pwm2_scale.sv
module pwm2_scale #(
    parameter int CW = 16,
    parameter int KW = 16,
    parameter int KF = 15
) (
    input  logic [CW-1:0] duty,
    input  logic [KW-1:0] ratio,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] d1,
    output logic [CW-1:0] d2
);
    localparam int PW = CW + KW;
    localparam int SW = PW - KF;

    logic [PW-1:0] prod;
    logic [SW-1:0] scaled;

    always_comb begin
        prod   = PW'(duty) * PW'(ratio);
        scaled = SW'(prod >> KF);
        d1     = (duty > per) ? per : duty;
        d2     = (scaled > SW'(per)) ? per : scaled[CW-1:0];
    end
endmodule

// File: rtl/pwm2_cmp.sv
module pwm2_cmp
    import pwm2_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] carrier,
    output gate_pair_t    pair
);
    gate_pair_t pair_d, pair_q;

    always_comb begin
        pair_d.gate   = (duty > carrier);
        pair_d.gate_n = (duty <= carrier);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= '{gate: 1'b0, gate_n: 1'b1};
        else        pair_q <= pair_d;
    end

    assign pair = pair_q;

    // R6
    complementary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_q.gate != pair_q.gate_n);
endmodule

// File: rtl/asym_pwm2.sv
module asym_pwm2
    import pwm2_pkg::*;
#(
    parameter int CW = 16,
    parameter int KW = 16,
    parameter int KF = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half_period,
    input  logic [CW-1:0] duty_cmd,
    input  logic [KW-1:0] ratio_k,
    output logic          gate_a,
    output logic          gate_a_n,
    output logic          gate_b,
    output logic          gate_b_n,
    output logic          sample_stb
);
    localparam int NPH = 2;

    typedef struct packed {
        logic [CW-1:0] d1;
        logic [CW-1:0] d2;
        logic          stb;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0] cnt_w, per_w, new_d1, new_d2;
    logic          valley_w, peak_w;
    logic [CW-1:0] car [NPH];
    logic [CW-1:0] dut [NPH];
    gate_pair_t    pairs [NPH];

    pwm2_carrier #(.CW(CW)) i_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .per_in (half_period),
        .cnt    (cnt_w),
        .per    (per_w),
        .valley (valley_w),
        .peak   (peak_w)
    );

    pwm2_scale #(.CW(CW), .KW(KW), .KF(KF)) i_scale (
        .duty  (duty_cmd),
        .ratio (ratio_k),
        .per   (half_period),
        .d1    (new_d1),
        .d2    (new_d2)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = valley_w | peak_w;
        if (valley_w) begin
            st_d.d1 = new_d1;
            st_d.d2 = new_d2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign car[0] = cnt_w;
    assign car[1] = per_w - cnt_w;
    assign dut[0] = st_q.d1;
    assign dut[1] = st_q.d2;

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        pwm2_cmp #(.CW(CW)) i_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .duty    (dut[g]),
            .carrier (car[g]),
            .pair    (pairs[g])
        );
    end

    assign gate_a     = pairs[0].gate;
    assign gate_a_n   = pairs[0].gate_n;
    assign gate_b     = pairs[1].gate;
    assign gate_b_n   = pairs[1].gate_n;
    assign sample_stb = st_q.stb;

    // R3 R5
    duty_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.d1 <= per_w) && (st_q.d2 <= per_w));

    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valley_w) |-> ($stable(st_q.d1) && $stable(st_q.d2)));

    // R4
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_w |-> (car[1] == per_w));
endmodule

// File: tb/test_asym_pwm2.sv
`timescale 1ns/1ps
module test_asym_pwm2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] half_period = '0;
    logic [15:0] duty_cmd = '0;
    logic [15:0] ratio_k = '0;
    logic        gate_a, gate_a_n, gate_b, gate_b_n, sample_stb;

    asym_pwm2 i_asym_pwm2 (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .duty_cmd(duty_cmd), .ratio_k(ratio_k),
        .gate_a(gate_a), .gate_a_n(gate_a_n), .gate_b(gate_b),
        .gate_b_n(gate_b_n), .sample_stb(sample_stb)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit ga; bit gan; bit gb; bit gbn; bit stb;
    } exp_t;

    exp_t   sb_q[$];
    int     total = 0;
    int     bad = 0;
    bit     done = 0;
    longint m_cnt = 0, m_per = 0, m_d1 = 0, m_d2 = 0;
    bit     m_up = 0;

    task automatic check(string tag, logic act, bit e);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, e, $time);
        end
    endtask

    // monitor: pops one expected item per clock
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check("R3 R7 gate_a", gate_a, e.ga);
            check("R6 gate_a_n", gate_a_n, e.gan);
            check("R4 R5 gate_b", gate_b, e.gb);
            check("R6 gate_b_n", gate_b_n, e.gbn);
            check("R2 R8 sample_stb", sample_stb, e.stb);
        end
    end

    // driver: applies inputs and pushes the outputs expected after the next edge
    task automatic drive(int per, int duty, int k, int n);
        for (int i = 0; i < n; i++) begin
            exp_t   e;
            longint s;
            @(negedge clk);
            #1;
            half_period = 16'(per);
            duty_cmd    = 16'(duty);
            ratio_k     = 16'(k);
            rst_n       = 1'b1;
            e.ga  = (m_d1 > m_cnt);
            e.gan = !e.ga;
            e.gb  = (m_d2 > (m_per - m_cnt));
            e.gbn = !e.gb;
            e.stb = (m_cnt == 0) || (m_cnt == m_per);
            sb_q.push_back(e);
            if (m_cnt == 0) begin
                m_per = per;
                m_d1  = (duty > per) ? per : duty;
                s     = (longint'(duty) * longint'(k)) >>> 15;
                m_d2  = (s > per) ? per : s;
                m_up  = 1;
                m_cnt = (per > 0) ? 1 : 0;
            end else if (m_up) begin
                if (m_cnt == m_per) begin
                    m_up  = 0;
                    m_cnt = m_cnt - 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held in reset
        check("R1 gate_a", gate_a, 1'b0);
        check("R1 gate_a_n", gate_a_n, 1'b1);
        check("R1 gate_b", gate_b, 1'b0);
        check("R1 gate_b_n", gate_b_n, 1'b1);
        check("R1 sample_stb", sample_stb, 1'b0);

        drive(20, 8, 16'h4CCD, 100);     // R3 R5 nominal ratio
        drive(20, 13, 16'h4CCD, 37);     // R7 change lands mid-period
        drive(20, 13, 16'h8000, 61);     // R5 unity ratio
        drive(20, 30, 16'hFFFF, 80);     // R3 R5 saturation at P
        drive(7, 0, 16'h4CCD, 40);       // zero duty
        drive(7, 7, 16'h4CCD, 43);       // R2 new period
        drive(1, 1, 16'h8000, 20);       // R8 peak and valley alternate
        drive(0, 5, 16'h4CCD, 10);       // R2 stopped carrier
        drive(1000, 600, 16'h4CCD, 4100); // nominal frequency and ratio

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule